// File: doc/BRIEF.md
# External interrupt flag register

This block keeps one sticky request flag for each of six external interrupt pins. Each line has its own two-bit sense mode, which selects low level, falling edge, rising edge or either edge. Every pin passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier. A detected condition sets the line's flag, and the flag stays set until something clears it.

Software reads the flags through a single-cycle register port and clears a flag by writing 0 to it. That write only works if an earlier read returned the flag as 1. Hardware can also clear a flag, in two ways:
- An exception-service acknowledge for the line. In level mode this clears the flag only while the synchronized pin is high. In the edge modes it clears the flag unconditionally.
- A transfer-controller trigger for the line, when the trigger's interrupt-select bit is 0.

Each line's request output is its flag gated by a per-line enable.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset every flag is 0, so the read data is 0x00 and every request output is 0.
- R2: With mode 00 (low level) on line n, a low pin sets flag n. The flag becomes visible on the third rising clock edge after the pin changes (two synchronizer stages plus the flag register).
- R3: With mode 01 (falling edge) a high-to-low pin transition sets the flag and a low-to-high transition does not. Line n's mode is `sense_mode_i[2n+1:2n]`, and bit 2n+1 is the upper mode bit.
- R4: With mode 10 (rising edge) a low-to-high transition sets the flag and a high-to-low transition does not.
- R5: With mode 11 (either edge) both transitions set the flag.
- R6: A register write clears flag n only when write data bit n is 0 and both of these hold:
  - the most recent read returned flag n as 1;
  - flag n has stayed 1 since that read.
  Any write consumes the read record. Writing 1 never clears a flag, and a write with no prior read clears nothing.
- R7: In level mode a service acknowledge clears flag n only if the synchronized pin is high in that cycle. Otherwise the flag stays 1.
- R8: In any edge mode a service acknowledge clears flag n in that cycle, unconditionally.
- R9: A transfer trigger on line n clears flag n when `xfer_isel_i` is 0 and leaves it unchanged when `xfer_isel_i` is 1.
- R10: When a set condition and a clear condition occur on one line in the same cycle, the flag ends up 1.
- R11: `reg_rdata_o[5:0]` shows flags 5..0 at bit positions 5..0 with no extra latency. Bits 7 and 6 always read 0, and writes to them have no effect.
- R12: `irq_req_o[n]` equals flag n ANDed with `irq_en_i[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 6 | External interrupt pins, asynchronous |
| sense_mode_i | input | 12 | Per-line sense mode, two bits per line |
| irq_en_i | input | 6 | Per-line request enable |
| svc_ack_i | input | 6 | Per-line exception-service acknowledge |
| xfer_trig_i | input | 6 | Per-line transfer-controller trigger |
| xfer_isel_i | input | 1 | Interrupt-select bit of the triggered transfer |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_req_o | output | 6 | Per-line request outputs |

## Verification
Every flag is visible at the read-data port in the cycle after it changes, so a wrong flag shows up on `reg_rdata_o` and on the matching `irq_req_o` bit one clock after the faulty update.

Two internal states are hidden and only show up later:
- A corrupted synchronizer or previous-value register appears as a flag that sets a cycle early, a cycle late, or on the wrong edge.
- A corrupted read record appears only at the next 0-write, as a flag that clears when it should not or survives when it should clear.

The bench therefore checks flag timing against a cycle-accurate model on every clock, and follows each read/write pair with a check.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH     = 6,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {WIDTH{RESET_VAL}};
      sync_q <= {WIDTH{RESET_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_flag_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      lvl_i,
  input  logic [MODE_W*N-1:0] mode_i,
  output logic [N-1:0]      set_o
);
  logic [N-1:0] prev_q;

  // idle-high lines: reset to 1 so release of reset makes no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    sense_e mode_g;
    logic   hit;
    assign mode_g = sense_e'(mode_i[MODE_W*g+1 -: MODE_W]);
    always_comb begin
      unique case (mode_g)
        SENSE_LOW:  hit = ~lvl_i[g];
        SENSE_FALL: hit = prev_q[g] & ~lvl_i[g];
        SENSE_RISE: hit = ~prev_q[g] & lvl_i[g];
        default:    hit = prev_q[g] ^ lvl_i[g];
      endcase
    end
    assign set_o[g] = hit;
  end
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core
  import irq_flag_pkg::*;
#(
  parameter int unsigned N  = 6,
  parameter int unsigned DW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        set_i,
  input  logic [N-1:0]        lvl_i,
  input  logic [MODE_W*N-1:0] mode_i,
  input  logic [N-1:0]        svc_ack_i,
  input  logic [N-1:0]        xfer_trig_i,
  input  logic                xfer_isel_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [N-1:0]        flag_o,
  output logic [N-1:0]        rd_latch_o
);
  logic [N-1:0] flag_q, flag_d, latch_q, latch_d, latch_n;
  logic [N-1:0] level_mode, clr_sw, clr_svc, clr_xfer;
  logic         unused_wdata_hi;

  for (genvar g = 0; g < N; g++) begin : g_mode
    assign level_mode[g] = (mode_i[MODE_W*g+1 -: MODE_W] == SENSE_LOW);
  end

  assign unused_wdata_hi = ^wdata_i[DW-1:N];

  assign clr_sw   = wr_i ? (latch_q & ~wdata_i[N-1:0]) : '0;
  assign clr_svc  = svc_ack_i & (~level_mode | lvl_i);
  assign clr_xfer = xfer_isel_i ? '0 : xfer_trig_i;

  // set has priority over every clear source
  assign flag_d  = set_i | (flag_q & ~(clr_sw | clr_svc | clr_xfer));
  assign latch_n = rd_i ? flag_q : (wr_i ? '0 : latch_q);
  assign latch_d = latch_n & flag_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      latch_q <= '0;
    end else begin
      flag_q  <= flag_d;
      latch_q <= latch_d;
    end
  end

  assign flag_o     = flag_q;
  assign rd_latch_o = latch_q;
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_LINES = 6,
  parameter int unsigned REG_W     = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LINES-1:0]        irq_pin_i,
  input  logic [MODE_W*NUM_LINES-1:0] sense_mode_i,
  input  logic [NUM_LINES-1:0]        irq_en_i,
  input  logic [NUM_LINES-1:0]        svc_ack_i,
  input  logic [NUM_LINES-1:0]        xfer_trig_i,
  input  logic                        xfer_isel_i,
  input  logic                        reg_rd_i,
  input  logic                        reg_wr_i,
  input  logic [REG_W-1:0]            reg_wdata_i,
  output logic [REG_W-1:0]            reg_rdata_o,
  output logic [NUM_LINES-1:0]        irq_req_o
);
  localparam int unsigned PAD_W = REG_W - NUM_LINES;

  logic [NUM_LINES-1:0] lvl_sync, set_vec, flag_q, rd_latch;

  irq_sync #(.WIDTH(NUM_LINES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_pin_i),
    .q_o   (lvl_sync)
  );

  irq_detect #(.N(NUM_LINES)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_sync),
    .mode_i(sense_mode_i),
    .set_o (set_vec)
  );

  irq_flag_core #(.N(NUM_LINES), .DW(REG_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .lvl_i      (lvl_sync),
    .mode_i     (sense_mode_i),
    .svc_ack_i  (svc_ack_i),
    .xfer_trig_i(xfer_trig_i),
    .xfer_isel_i(xfer_isel_i),
    .rd_i       (reg_rd_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .flag_o     (flag_q),
    .rd_latch_o (rd_latch)
  );

  assign reg_rdata_o = {{PAD_W{1'b0}}, flag_q};
  assign irq_req_o   = flag_q & irq_en_i;
endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk #(
  parameter int unsigned N  = 6,
  parameter int unsigned DW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [2*N-1:0] sense_mode_i,
  input logic [N-1:0]   irq_en_i,
  input logic [N-1:0]   svc_ack_i,
  input logic [N-1:0]   xfer_trig_i,
  input logic           xfer_isel_i,
  input logic           reg_wr_i,
  input logic [DW-1:0]  reg_rdata_o,
  input logic [N-1:0]   irq_req_o,
  input logic [N-1:0]   flag,
  input logic [N-1:0]   set_vec,
  input logic [N-1:0]   rd_latch
);
  logic [N-1:0] edge_mask;
  for (genvar g = 0; g < N; g++) begin : g_em
    assign edge_mask[g] = |sense_mode_i[2*g+1 -: 2];
  end

  p_rsvd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DW-1:N] == '0);

  p_req_mask_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o == (reg_rdata_o[N-1:0] & irq_en_i));

  p_new_flag_needs_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag & ~$past(flag) & ~$past(set_vec)) == '0));

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_vec) & ~flag) == '0));

  p_edge_svc_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag & $past(svc_ack_i & edge_mask & ~set_vec)) == '0));

  p_unread_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_ack_i == '0 && (xfer_isel_i || xfer_trig_i == '0))
    |=> (($past(flag & ~rd_latch) & ~flag) == '0));

  p_isel_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_isel_i && svc_ack_i == '0 && !reg_wr_i)
    |=> (($past(flag) & ~flag) == '0));
endmodule

bind ext_irq_flags ext_irq_flags_chk #(.N(NUM_LINES), .DW(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sense_mode_i(sense_mode_i),
  .irq_en_i    (irq_en_i),
  .svc_ack_i   (svc_ack_i),
  .xfer_trig_i (xfer_trig_i),
  .xfer_isel_i (xfer_isel_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_req_o   (irq_req_o),
  .flag        (flag_q),
  .set_vec     (set_vec),
  .rd_latch    (rd_latch)
);

// File: tb/test_ext_irq_flags.sv
`timescale 1ns/1ps
module test_ext_irq_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  pin = 6'h3f;
  logic [11:0] mode = 12'h0E4; // l5..l0 = low,low,both,rise,fall,low
  logic [5:0]  en = 6'h3f;
  logic [5:0]  svc = '0;
  logic [5:0]  trig = '0;
  logic        isel = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [5:0]  req;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ext_irq_flags i_ext_irq_flags (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pin), .sense_mode_i(mode),
    .irq_en_i(en), .svc_ack_i(svc), .xfer_trig_i(trig), .xfer_isel_i(isel),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_req_o(req)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // behavioural reference: pin history queue, flags and read record
  bit [5:0] m_flag = '0;
  bit [5:0] m_rec = '0;
  bit [5:0] hist[$];

  always @(posedge clk) begin
    bit [5:0] nf, nr;
    bit s, p, st, cl;
    bit [1:0] md;
    if (!rst_n) begin
      m_flag = '0;
      m_rec = '0;
      hist = {6'h3f, 6'h3f, 6'h3f};
    end else begin
      for (int i = 0; i < 6; i++) begin
        s  = hist[$-1][i];
        p  = hist[$-2][i];
        md = {mode[2*i+1], mode[2*i]};
        case (md)
          2'b00:   st = !s;
          2'b01:   st = p && !s;
          2'b10:   st = !p && s;
          default: st = p != s;
        endcase
        cl = (svc[i] && (md != 2'b00 || s)) || (trig[i] && !isel) ||
             (wr && m_rec[i] && !wdata[i]);
        nf[i] = st ? 1'b1 : (cl ? 1'b0 : m_flag[i]);
      end
      nr = rd ? m_flag : (wr ? 6'h00 : m_rec);
      m_rec = nr & nf;
      m_flag = nf;
      hist.push_back(pin);
      if (hist.size() > 4) void'(hist.pop_front());
    end
    #2;
    chk(rdata, {2'b00, m_flag}, "R11 model rdata");
    chk({2'b00, req}, {2'b00, m_flag & en}, "R12 model req");
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1; tick(1); rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr = 1'b1; wdata = d; tick(1); wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse_svc(input logic [5:0] v);
    svc = v; tick(1); svc = '0;
  endtask

  task automatic pulse_trig(input logic [5:0] v, input logic sel);
    trig = v; isel = sel; tick(1); trig = '0; isel = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(rdata, 8'h00, "R1 reset rdata");
    chk({2'b00, req}, 8'h00, "R1 reset req");

    // R2 level on line 0
    pin[0] = 1'b0;
    tick(2);
    chk(rdata, 8'h00, "R2 latency two edges");
    tick(1);
    chk(rdata, 8'h01, "R2 level set");
    pin[0] = 1'b1;
    tick(3);

    // R6 software clear
    do_write(8'h00);
    chk(rdata, 8'h01, "R6 write without read");
    do_read();
    do_write(8'hFF);
    chk(rdata, 8'h01, "R6 write one ignored");
    chk(rdata & 8'hC0, 8'h00, "R11 upper bits zero");
    do_write(8'h00);
    chk(rdata, 8'h01, "R6 record consumed");
    do_read();
    do_write(8'h00);
    chk(rdata, 8'h00, "R6 read then write zero");

    // R3 falling on line 1, R8 edge service clear
    pin[1] = 1'b0;
    tick(3);
    chk(rdata, 8'h02, "R3 falling set");
    pulse_svc(6'h02);
    chk(rdata, 8'h00, "R8 edge service clear");
    pin[1] = 1'b1;
    tick(4);
    chk(rdata, 8'h00, "R3 rising ignored");

    // R4 rising on line 2
    pin[2] = 1'b0;
    tick(4);
    chk(rdata, 8'h00, "R4 falling ignored");
    pin[2] = 1'b1;
    tick(3);
    chk(rdata, 8'h04, "R4 rising set");

    // R5 both edges on line 3, R9 transfer clear
    pin[3] = 1'b0;
    tick(3);
    chk(rdata, 8'h0C, "R5 falling set");
    pulse_trig(6'h08, 1'b0);
    chk(rdata, 8'h04, "R9 trigger isel0 clears");
    pin[3] = 1'b1;
    tick(3);
    chk(rdata, 8'h0C, "R5 rising set");
    pulse_trig(6'h08, 1'b1);
    chk(rdata, 8'h0C, "R9 trigger isel1 keeps");

    // R12 enable gating
    en = 6'h08;
    tick(1);
    chk({2'b00, req}, 8'h08, "R12 req line3 only");
    en = 6'h04;
    tick(1);
    chk({2'b00, req}, 8'h04, "R12 req line2 only");
    en = 6'h00;
    tick(1);
    chk({2'b00, req}, 8'h00, "R12 req all masked");
    en = 6'h3f;

    // R7 level service on line 4
    pin[4] = 1'b0;
    tick(3);
    chk(rdata, 8'h1C, "R7 level set");
    pulse_svc(6'h10);
    chk(rdata, 8'h1C, "R7 service with pin low keeps");
    pin[4] = 1'b1;
    tick(3);
    pulse_svc(6'h10);
    chk(rdata, 8'h0C, "R7 service with pin high clears");

    // R10 set wins on line 5 (level, pin held low)
    pin[5] = 1'b0;
    tick(3);
    chk(rdata, 8'h2C, "R10 level set");
    pulse_trig(6'h20, 1'b0);
    chk(rdata, 8'h2C, "R10 set beats trigger clear");
    do_read();
    do_write(8'h00);
    chk(rdata, 8'h20, "R10 set beats software clear");
    pin[5] = 1'b1;
    tick(3);
    do_read();
    do_write(8'h00);
    chk(rdata, 8'h00, "R6 clear after pin released");

    tick(2);
    summary();
    $finish;
  end
endmodule